// File: doc/BRIEF.md
# Jitter Attenuator Elastic Store

This block is a per-channel elastic buffer for single-bit line data. A jittered write strobe pushes bits into it, and a smoothed read strobe pulls them out. The read strobe comes from an external clock-smoothing loop, which is not part of this block. Holding a window of bits between the two strobes absorbs the short-term phase wander of the incoming clock. The line data that leaves the block then follows the smoothed timing.

A three-bit select code switches the store on or off and sets its usable depth to 8, 16, 32, 64 or 128 bits. A direction input places the store in either the receive path or the transmit path. The path that is not buffered, or both paths when the store is off, passes through a single register. The read pointer is recentered half a depth behind the write pointer in four cases: after reset, on command, on any overflow or underflow, and whenever the select code or direction changes. An overflow or underflow raises a sticky error flag. Only a centering command or reset clears it.

The block runs in one clock domain. Both strobes are single-cycle enables sampled on the system clock.

Top module: `jat_elastic_store`

## Requirements
- R1: During reset and on the first cycle after it, `err`, `rx_dout` and `tx_dout` are 0. Reset leaves the store holding half the selected depth.
- R2: Select codes 1 to 5 enable the store with depths 8, 16, 32, 64 and 128 (8 << (code-1)). Codes 0, 6 and 7 disable it.
- R3: While the store is disabled, `rx_dout` and `tx_dout` equal `rx_din` and `tx_din` delayed by exactly one clock, and the strobes have no effect on them.
- R4: With `path_tx` = 0 the store sits between `rx_din`/`rx_wen` and `rx_dout`, and `tx_dout` is `tx_din` delayed one clock. With `path_tx` = 1 the roles are swapped.
- R5: Bits leave in the order they were written. Each `rd_en` cycle loads the next bit into the buffered output register, visible after that edge. Without `rd_en` the output holds.
- R6: A write when the store already holds the full depth is an overflow and sets `err` after that edge. The write itself still lands. Filling to exactly the depth sets no error.
- R7: A read when the store is empty is an underflow and sets `err` after that edge.
- R8: On the same edge as an overflow or underflow, the read pointer moves to half the depth behind the updated write pointer. The next reads then return the most recent half-depth of written bits.
- R9: A `center_req` cycle recenters the read pointer the same way and clears `err`.
- R10: A change of the select code or of `path_tx` forces a recenter at the new depth on the edge where the change is first seen.
- R11: `err` stays high after an overflow or underflow until `center_req` or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| jsel | input | 3 | Enable and depth select code |
| path_tx | input | 1 | 0: store in receive path, 1: store in transmit path |
| rx_din | input | 1 | Receive line bit |
| rx_wen | input | 1 | Receive write strobe (jittered clock) |
| tx_din | input | 1 | Transmit line bit |
| tx_wen | input | 1 | Transmit write strobe (jittered clock) |
| rd_en | input | 1 | Smoothed read strobe |
| center_req | input | 1 | Commanded recenter and error clear |
| rx_dout | output | 1 | Receive line bit out |
| tx_dout | output | 1 | Transmit line bit out |
| err | output | 1 | Sticky overflow/underflow flag |

## Verification
The bench writes to the store until it holds exactly the full depth. It then writes one bit more, at depths 8, 16 and 128. A design with an off-by-one fill limit would flag the error one bit early or one bit late, and one that ignored a depth change would overflow at the old depth's threshold. After an overflow, an underflow and a commanded recenter, the bench reads back the bits and compares them with the last half-depth it wrote. A pointer placed at the wrong offset, or moved one cycle late, returns stale or shifted bits. The bench also checks that the unbuffered path lags by exactly one clock and not zero, and that the error flag persists across ordinary reads until it is cleared.

// File: rtl/jat_pkg.sv
package jat_pkg;
  // smallest supported store depth, as a log2 value
  localparam int unsigned JAT_MIN_LG = 3;

  // log2 of the depth chosen by a nonzero select code
  function automatic int unsigned jat_lg(input int unsigned code);
    return code + JAT_MIN_LG - 1;
  endfunction
endpackage

// File: rtl/jat_mode_dec.sv
module jat_mode_dec
  import jat_pkg::*;
#(
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned MAX_LG = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  sel,
  input  logic              dir,
  output logic              en,
  output logic [MAX_LG:0]   depth,
  output logic [MAX_LG:0]   half,
  output logic              chg
);
  localparam int unsigned DW = MAX_LG + 1;

  logic [SEL_W-1:0] sel_q;
  logic             dir_q;
  int unsigned      lg;

  always_comb begin
    lg    = jat_lg(32'(sel));
    en    = (sel != '0) && (lg <= MAX_LG);
    depth = en ? (DW'(1) << lg) : '0;
    half  = depth >> 1;
    chg   = (sel != sel_q) || (dir != dir_q);
  end

  always_ff @(posedge clk) begin
    sel_q <= sel;
    dir_q <= dir;
  end
endmodule

// File: rtl/jat_bit_ram.sv
module jat_bit_ram #(
  parameter int unsigned AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic          rbit
);
  localparam int unsigned WORDS = 1 << AW;

  logic mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wbit;
  end

  always_ff @(posedge clk) begin
    if (rst)     rbit <= 1'b0;
    else if (re) rbit <= mem[raddr];
  end
endmodule

// File: rtl/jat_ptr_ctl.sv
module jat_ptr_ctl #(
  parameter int unsigned MAX_LG = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [MAX_LG:0]   depth,
  input  logic [MAX_LG:0]   half,
  input  logic              chg,
  input  logic              wstb,
  input  logic              rstb,
  input  logic              center,
  output logic              we,
  output logic [MAX_LG-1:0] waddr,
  output logic              re,
  output logic [MAX_LG-1:0] raddr,
  output logic              err
);
  localparam int unsigned PW = MAX_LG;
  localparam int unsigned DW = MAX_LG + 1;

  logic [PW-1:0] wptr, rptr, wptr_n, mask;
  logic [DW-1:0] fill;
  logic          wr, rd, ovf, unf, recenter;

  always_comb begin
    wr       = en & wstb;
    rd       = en & rstb;
    ovf      = wr && (fill == depth);
    unf      = rd && (fill == '0);
    recenter = center | chg | ovf | unf;
    mask     = PW'(depth - DW'(1));
    wptr_n   = wptr + PW'(wr);
    waddr    = wptr & mask;
    raddr    = rptr & mask;
    we       = wr;
    re       = rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0 - PW'(half);
      fill <= half;
    end else begin
      wptr <= wptr_n;
      if (recenter) begin
        rptr <= wptr_n - PW'(half);
        fill <= half;
      end else begin
        rptr <= rptr + PW'(rd);
        fill <= fill + DW'(wr) - DW'(rd);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              err <= 1'b0;
    else if (center)      err <= 1'b0;
    else if (ovf || unf)  err <= 1'b1;
  end

  // R6
  fill_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !chg) |-> (fill <= depth));

  // R10
  chg_center_chk: assert property (@(posedge clk) disable iff (rst)
    chg |=> (fill == $past(half)));

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (err && !center) |=> err);

  // R9
  center_clr_chk: assert property (@(posedge clk) disable iff (rst)
    center |=> !err);
endmodule

// File: rtl/jat_elastic_store.sv
module jat_elastic_store #(
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned MAX_LG = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] jsel,
  input  logic             path_tx,
  input  logic             rx_din,
  input  logic             rx_wen,
  input  logic             tx_din,
  input  logic             tx_wen,
  input  logic             rd_en,
  input  logic             center_req,
  output logic             rx_dout,
  output logic             tx_dout,
  output logic             err
);
  logic              en, chg, wbit, wstb, we, re, rbit;
  logic [MAX_LG:0]   depth, half;
  logic [MAX_LG-1:0] waddr, raddr;
  logic              rx_q, tx_q;

  jat_mode_dec #(.SEL_W(SEL_W), .MAX_LG(MAX_LG)) u_dec (
    .clk(clk), .rst(rst), .sel(jsel), .dir(path_tx),
    .en(en), .depth(depth), .half(half), .chg(chg)
  );

  always_comb begin
    wbit = path_tx ? tx_din : rx_din;
    wstb = path_tx ? tx_wen : rx_wen;
  end

  jat_ptr_ctl #(.MAX_LG(MAX_LG)) u_ctl (
    .clk(clk), .rst(rst), .en(en), .depth(depth), .half(half), .chg(chg),
    .wstb(wstb), .rstb(rd_en), .center(center_req),
    .we(we), .waddr(waddr), .re(re), .raddr(raddr), .err(err)
  );

  jat_bit_ram #(.AW(MAX_LG)) u_ram (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wbit(wbit),
    .re(re), .raddr(raddr), .rbit(rbit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q <= 1'b0;
      tx_q <= 1'b0;
    end else begin
      rx_q <= rx_din;
      tx_q <= tx_din;
    end
  end

  always_comb begin
    rx_dout = (en && !path_tx) ? rbit : rx_q;
    tx_dout = (en &&  path_tx) ? rbit : tx_q;
  end

  // R1
  reset_err_chk: assert property (@(posedge clk) rst |=> !err);

  // R3
  bypass_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !$past(rst)) |-> (rx_dout == $past(rx_din) && tx_dout == $past(tx_din)));

  // R4
  other_path_chk: assert property (@(posedge clk) disable iff (rst)
    (en && path_tx && !$past(rst)) |-> (rx_dout == $past(rx_din)));
endmodule

// File: tb/sim_jat_elastic_store.sv
module sim_jat_elastic_store;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] jsel;
  logic       path_tx, rx_din, rx_wen, tx_din, tx_wen, rd_en, center_req;
  logic       rx_dout, tx_dout, err;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  jat_elastic_store u0 (
    .clk(clk), .rst(rst), .jsel(jsel), .path_tx(path_tx),
    .rx_din(rx_din), .rx_wen(rx_wen), .tx_din(tx_din), .tx_wen(tx_wen),
    .rd_en(rd_en), .center_req(center_req),
    .rx_dout(rx_dout), .tx_dout(tx_dout), .err(err)
  );

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic put(input logic b);
    if (path_tx) begin tx_din = b; tx_wen = 1'b1; end
    else         begin rx_din = b; rx_wen = 1'b1; end
    tick();
    rx_wen = 1'b0;
    tx_wen = 1'b0;
  endtask

  task automatic take(output logic b);
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    b = path_tx ? tx_dout : rx_dout;
  endtask

  task automatic center();
    center_req = 1'b1;
    tick();
    center_req = 1'b0;
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) tick();
    chk("R1 err in reset", err, 1'b0);
    rst = 1'b0;
    chk("R1 rx_dout after reset", rx_dout, 1'b0);
    chk("R1 tx_dout after reset", tx_dout, 1'b0);
    chk("R1 err after reset", err, 1'b0);
  endtask

  task automatic test_overflow();
    logic b;
    logic e [4] = '{1'b0, 1'b1, 1'b1, 1'b1};
    put(1'b1); put(1'b0); put(1'b1); put(1'b1);
    chk("R6 exactly full no error", err, 1'b0);
    put(1'b1);
    chk("R6 overflow flags", err, 1'b1);
    for (int i = 0; i < 4; i++) begin
      take(b);
      chk("R8 overflow recenter data", b, e[i]);
    end
    tick();
    chk("R5 output holds without read", rx_dout, 1'b1);
    chk("R11 error sticky over reads", err, 1'b1);
  endtask

  task automatic test_center_underflow();
    logic b;
    logic e [4] = '{1'b0, 1'b1, 1'b1, 1'b1};
    center();
    chk("R9 center clears error", err, 1'b0);
    for (int i = 0; i < 4; i++) begin
      take(b);
      chk("R9 manual recenter data", b, e[i]);
    end
    chk("R7 empty no error yet", err, 1'b0);
    take(b);
    chk("R7 underflow flags", err, 1'b1);
    for (int i = 0; i < 4; i++) begin
      take(b);
      chk("R8 underflow recenter data", b, e[i]);
    end
  endtask

  task automatic test_depth();
    center();
    jsel = 3'd2;
    tick();
    for (int i = 0; i < 8; i++) put(i[0]);
    chk("R10 depth16 recentered not full", err, 1'b0);
    put(1'b0);
    chk("R10 depth16 overflow at 17th", err, 1'b1);
    center();
    jsel = 3'd5;
    tick();
    for (int i = 0; i < 64; i++) put(i[1]);
    chk("R2 depth128 holds 128", err, 1'b0);
    put(1'b1);
    chk("R2 depth128 overflow", err, 1'b1);
  endtask

  task automatic test_dir();
    logic b;
    logic e [4] = '{1'b1, 1'b1, 1'b0, 1'b1};
    center();
    jsel = 3'd1;
    path_tx = 1'b1;
    tick();
    for (int i = 0; i < 4; i++) put(e[i]);
    chk("R10 dir change recentered", err, 1'b0);
    for (int i = 0; i < 4; i++) take(b);
    for (int i = 0; i < 4; i++) begin
      take(b);
      chk("R4 tx path buffered data", b, e[i]);
    end
    rx_din = 1'b1;
    tick();
    chk("R4 rx path passes through", rx_dout, 1'b1);
    rx_din = 1'b0;
    tick();
    chk("R4 rx path passes through", rx_dout, 1'b0);
  endtask

  task automatic test_bypass();
    logic p [6] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    jsel = 3'd0;
    path_tx = 1'b0;
    for (int i = 0; i < 6; i++) begin
      rx_din = p[i];
      tx_din = ~p[i];
      rd_en  = i[0];
      rx_wen = 1'b1;
      tick();
      chk("R3 rx bypass", rx_dout, p[i]);
      chk("R3 tx bypass", tx_dout, ~p[i]);
    end
    rd_en = 1'b0;
    rx_wen = 1'b0;
    rx_din = 1'b1;
    #1;
    chk("R3 no zero-latency path", rx_dout, 1'b0);
    tick();
    chk("R3 one-cycle latency", rx_dout, 1'b1);
  endtask

  task automatic test_invalid_code();
    jsel = 3'd6;
    rx_din = 1'b0;
    tick();
    rx_din = 1'b1;
    tick();
    chk("R2 code 6 disables store", rx_dout, 1'b1);
    jsel = 3'd7;
    rx_din = 1'b0;
    tick();
    chk("R2 code 7 disables store", rx_dout, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; jsel = 3'd1; path_tx = 1'b0;
    rx_din = 1'b0; rx_wen = 1'b0; tx_din = 1'b0; tx_wen = 1'b0;
    rd_en = 1'b0; center_req = 1'b0;
    test_reset();
    test_overflow();
    test_center_underflow();
    test_depth();
    test_dir();
    test_bypass();
    test_invalid_code();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule